// File: doc/BRIEF.md
# Supply Power State Sequencer

This block decides whether a low-power converter controller is asleep, warming up, or running, based on the state of its own supply rail. Two comparator decisions on the supply arrive as digital levels: one reports that the rail has climbed past the wake threshold, the other that it has sagged below the undervoltage threshold. A third input is a thermal flag whose hysteresis is applied upstream. All three levels are resynchronised to the controller clock before they are used.

From reset the sequencer sits in Sleep. In Sleep the shunt regulator is off and the switch drive is clamped. A wake decision with no undervoltage moves it to Start-up. Start-up enables the regulator at its higher intermediate target, lets conversion begin, and sends a one-cycle request that resets the power conversion mode to Standby. After a fixed number of clock cycles the sequencer moves to Active and the regulator drops to its run target. An undervoltage decision in either powered state sends it straight back to Sleep. An over-temperature flag clamps the switch drive without changing the state, and the drive is released once the flag clears.

Top module: `supply_state_seq`

## Requirements
- R1: After reset the state is Sleep: `state_oh_o` = 3'b001, `reg_en_o` = 0, `conv_en_o` = 0, `drive_hold_o` = 1 and `force_standby_o` = 0.
- R2: In Sleep, a high `wake_cmp_i` with a low `uv_cmp_i` moves the block to Start-up on the third rising clock edge after the input changes (two synchroniser stages plus the state register). If `uv_cmp_i` is also high, the block stays in Sleep, and `uv_cmp_i` alone has no effect in Sleep.
- R3: Start-up lasts exactly STARTUP_CYCLES clock cycles and then moves to Active whatever the level of `wake_cmp_i`. Active is never entered directly from Sleep, and `wake_cmp_i` has no effect in Active.
- R4: `reg_en_o` is 1 in Start-up and in Active and 0 in Sleep. `reg_hi_sel_o` is 1 (higher start-up target) in Start-up and 0 (run target) in Active.
- R5: In Start-up or Active, a high `uv_cmp_i` returns the block to Sleep on the third rising edge after the input changes, with `conv_en_o` = 0 and `drive_hold_o` = 1. Undervoltage wins over the end of the Start-up interval when both fall in the same cycle.
- R6: `force_standby_o` is high for exactly one cycle, the first cycle of Start-up, and is low at all other times.
- R7: `drive_hold_o` follows `hot_i` two rising edges after each change while the block is powered. `hot_i` changes neither the state nor the progress of the Start-up timer.
- R8: `state_oh_o` is one-hot: bit 0 Sleep, bit 1 Start-up, bit 2 Active. An unused state encoding leads to Sleep on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_cmp_i | input | 1 | Supply is above the wake threshold (asynchronous) |
| uv_cmp_i | input | 1 | Supply is below the undervoltage threshold (asynchronous) |
| hot_i | input | 1 | Over-temperature flag with hysteresis (asynchronous) |
| reg_en_o | output | 1 | Shunt regulator enable |
| reg_hi_sel_o | output | 1 | Regulator target: 1 start-up level, 0 run level |
| conv_en_o | output | 1 | Power conversion enable |
| force_standby_o | output | 1 | One-cycle request to reset the conversion mode to Standby |
| drive_hold_o | output | 1 | Holds the switch drive off |
| state_oh_o | output | 3 | One-hot state: bit 0 Sleep, bit 1 Start-up, bit 2 Active |

## Verification
Every output is decoded directly from the state register or from the last synchroniser stage, so a wrong state shows at the ports in the same cycle it is entered. It shows as a bad one-hot code, a wrong regulator target, or a drive clamp out of step with the state. A fault in the Start-up timer shows as Active arriving one or more cycles early or late, so the bench samples the state on the exact cycle Start-up should end and on the cycle before it. Latency faults in the synchronisers show as a transition one edge away from the third edge after the stimulus.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

    typedef enum logic [1:0] {
        PS_SLEEP = 2'b00,
        PS_START = 2'b01,
        PS_RUN   = 2'b10
    } pstate_e;

    typedef struct packed {
        pstate_e st;
        logic    stby;
    } fsm_regs_t;

    localparam int unsigned SYNC_LANES = 3;
    localparam int unsigned LANE_WAKE  = 0;
    localparam int unsigned LANE_UV    = 1;
    localparam int unsigned LANE_HOT   = 2;

    localparam int unsigned STATE_BITS = 3;

endpackage

// File: rtl/supply_seq_sync.sv
module supply_seq_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/supply_seq_timer.sv
module supply_seq_timer #(
    parameter int unsigned CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;
    logic          at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        if (!run_i || at_last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && at_last;

endmodule

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
    import supply_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wake_i,
    input  logic    uv_i,
    input  logic    expire_i,
    output pstate_e st_o,
    output logic    stby_o
);

    fsm_regs_t r_d;
    fsm_regs_t r_q;

    always_comb begin
        r_d      = r_q;
        r_d.stby = 1'b0;
        case (r_q.st)
            PS_SLEEP: begin
                if (wake_i && !uv_i) begin
                    r_d.st   = PS_START;
                    r_d.stby = 1'b1;
                end
            end
            PS_START: begin
                if (uv_i) begin
                    r_d.st = PS_SLEEP;
                end else if (expire_i) begin
                    r_d.st = PS_RUN;
                end
            end
            PS_RUN: begin
                if (uv_i) begin
                    r_d.st = PS_SLEEP;
                end
            end
            default: begin
                r_d.st = PS_SLEEP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= PS_SLEEP;
            r_q.stby <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o   = r_q.st;
    assign stby_o = r_q.stby;

endmodule

// File: rtl/supply_state_seq.sv
module supply_state_seq
    import supply_seq_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 1024,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wake_cmp_i,
    input  logic                  uv_cmp_i,
    input  logic                  hot_i,
    output logic                  reg_en_o,
    output logic                  reg_hi_sel_o,
    output logic                  conv_en_o,
    output logic                  force_standby_o,
    output logic                  drive_hold_o,
    output logic [STATE_BITS-1:0] state_oh_o
);

    logic [SYNC_LANES-1:0] raw;
    logic [SYNC_LANES-1:0] synced;
    logic                  expire;
    logic                  stby;
    pstate_e               st;

    always_comb begin
        raw            = '0;
        raw[LANE_WAKE] = wake_cmp_i;
        raw[LANE_UV]   = uv_cmp_i;
        raw[LANE_HOT]  = hot_i;
    end

    supply_seq_sync #(
        .WIDTH  (SYNC_LANES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    supply_seq_timer #(
        .CYCLES (STARTUP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st == PS_START),
        .expire_o (expire)
    );

    supply_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_i   (synced[LANE_WAKE]),
        .uv_i     (synced[LANE_UV]),
        .expire_i (expire),
        .st_o     (st),
        .stby_o   (stby)
    );

    always_comb begin
        state_oh_o      = '0;
        state_oh_o[0]   = (st == PS_SLEEP);
        state_oh_o[1]   = (st == PS_START);
        state_oh_o[2]   = (st == PS_RUN);
        reg_en_o        = (st == PS_START) || (st == PS_RUN);
        reg_hi_sel_o    = (st == PS_START);
        conv_en_o       = reg_en_o;
        force_standby_o = stby;
        drive_hold_o    = (st != PS_START && st != PS_RUN) || synced[LANE_HOT];
    end

endmodule

// File: rtl/supply_state_seq_chk.sv
module supply_state_seq_chk #(
    parameter int unsigned STARTUP_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hot_i,
    input logic       reg_en_o,
    input logic       reg_hi_sel_o,
    input logic       conv_en_o,
    input logic       force_standby_o,
    input logic       drive_hold_o,
    input logic [2:0] state_oh_o
);

    logic [31:0] start_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_len_q <= '0;
        end else if (state_oh_o[1]) begin
            start_len_q <= start_len_q + 32'd1;
        end else begin
            start_len_q <= '0;
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh_o) == 1); // R8

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh_o[0] |-> (!reg_en_o && !conv_en_o && drive_hold_o)); // R1

    AST_POWERED_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        !state_oh_o[0] |-> (conv_en_o && reg_en_o)); // R5

    AST_START_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh_o[1] |-> reg_hi_sel_o); // R4

    AST_RUN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh_o[2] |-> !reg_hi_sel_o); // R4

    AST_STBY_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        force_standby_o |-> (state_oh_o[1] && $past(state_oh_o[0]))); // R6

    AST_ENTRY_GIVES_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh_o[1]) |-> force_standby_o); // R6

    AST_NO_SKIP_START: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh_o[0] |=> !state_oh_o[2]); // R3

    AST_START_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh_o[1] |-> (start_len_q < STARTUP_CYCLES)); // R3

    AST_START_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh_o[2]) |-> ($past(start_len_q) == STARTUP_CYCLES - 1)); // R3

    AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hot_i, 2) && $past(rst_n, 2)) |-> drive_hold_o); // R7

    AST_COOL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hot_i, 2) && $past(rst_n, 2) && !state_oh_o[0]) |-> !drive_hold_o); // R7

endmodule

bind supply_state_seq supply_state_seq_chk #(
    .STARTUP_CYCLES (STARTUP_CYCLES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hot_i           (hot_i),
    .reg_en_o        (reg_en_o),
    .reg_hi_sel_o    (reg_hi_sel_o),
    .conv_en_o       (conv_en_o),
    .force_standby_o (force_standby_o),
    .drive_hold_o    (drive_hold_o),
    .state_oh_o      (state_oh_o)
);

// File: tb/supply_state_seq_test.sv
`timescale 1ns/1ps
module supply_state_seq_test;

    localparam int unsigned N = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 1'b0;
    logic       uv = 1'b0;
    logic       hot = 1'b0;
    logic       reg_en;
    logic       reg_hi;
    logic       conv_en;
    logic       stby;
    logic       hold;
    logic [2:0] st;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    supply_state_seq #(
        .STARTUP_CYCLES (N),
        .SYNC_STAGES    (2)
    ) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .wake_cmp_i      (wake),
        .uv_cmp_i        (uv),
        .hot_i           (hot),
        .reg_en_o        (reg_en),
        .reg_hi_sel_o    (reg_hi),
        .conv_en_o       (conv_en),
        .force_standby_o (stby),
        .drive_hold_o    (hold),
        .state_oh_o      (st)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_startup();
        wake = 1'b1;
        step(2);
        chk("R2", "state before third edge", 32'(st), 32'h1);
        step(1);
        chk("R2", "state on third edge", 32'(st), 32'h2);
        chk("R6", "standby request on entry", 32'(stby), 32'h1);
        chk("R4", "start target", 32'(reg_hi), 32'h1);
        chk("R4", "regulator on in start-up", 32'(reg_en), 32'h1);
        wake = 1'b0;
    endtask

    task automatic go_active();
        go_startup();
        step(1);
        chk("R6", "standby request one cycle", 32'(stby), 32'h0);
        step(int'(N) - 2);
        chk("R3", "last start-up cycle", 32'(st), 32'h2);
        step(1);
        chk("R3", "active after full interval", 32'(st), 32'h4);
        chk("R4", "run target", 32'(reg_hi), 32'h0);
        chk("R4", "regulator on in active", 32'(reg_en), 32'h1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1", "state", 32'(st), 32'h1);
        chk("R1", "reg_en", 32'(reg_en), 32'h0);
        chk("R1", "conv_en", 32'(conv_en), 32'h0);
        chk("R1", "drive_hold", 32'(hold), 32'h1);
        chk("R1", "force_standby", 32'(stby), 32'h0);
    endtask

    task automatic t_sleep_blocked();
        uv = 1'b1;
        step(6);
        chk("R2", "uv alone in sleep", 32'(st), 32'h1);
        chk("R2", "regulator stays off", 32'(reg_en), 32'h0);
        wake = 1'b1;
        step(6);
        chk("R2", "wake with uv stays asleep", 32'(st), 32'h1);
        chk("R6", "no standby request", 32'(stby), 32'h0);
        wake = 1'b0;
        uv = 1'b0;
        step(3);
    endtask

    task automatic t_wake_ignored_active();
        wake = 1'b1;
        step(8);
        chk("R3", "wake in active", 32'(st), 32'h4);
        chk("R4", "target stays run", 32'(reg_hi), 32'h0);
        chk("R6", "no request in active", 32'(stby), 32'h0);
        wake = 1'b0;
        step(3);
    endtask

    task automatic t_hot_active();
        hot = 1'b1;
        step(1);
        chk("R7", "hold after one edge", 32'(hold), 32'h0);
        step(1);
        chk("R7", "hold after two edges", 32'(hold), 32'h1);
        step(20);
        chk("R7", "state unchanged while hot", 32'(st), 32'h4);
        chk("R7", "conversion kept", 32'(conv_en), 32'h1);
        hot = 1'b0;
        step(1);
        chk("R7", "hold one edge after clear", 32'(hold), 32'h1);
        step(1);
        chk("R7", "released two edges after clear", 32'(hold), 32'h0);
    endtask

    task automatic t_uv_active();
        uv = 1'b1;
        step(2);
        chk("R5", "active before third edge", 32'(st), 32'h4);
        step(1);
        chk("R5", "sleep on third edge", 32'(st), 32'h1);
        chk("R5", "conversion stops", 32'(conv_en), 32'h0);
        chk("R5", "drive held", 32'(hold), 32'h1);
        chk("R4", "regulator off in sleep", 32'(reg_en), 32'h0);
        uv = 1'b0;
        step(3);
    endtask

    task automatic t_uv_at_expiry();
        go_startup();
        step(int'(N) - 3);
        uv = 1'b1;
        step(2);
        chk("R5", "still start-up", 32'(st), 32'h2);
        step(1);
        chk("R5", "uv wins over expiry", 32'(st), 32'h1);
        uv = 1'b0;
        step(3);
        chk("R5", "stays asleep", 32'(st), 32'h1);
    endtask

    task automatic t_hot_startup();
        go_startup();
        hot = 1'b1;
        step(2);
        chk("R7", "hold in start-up", 32'(hold), 32'h1);
        chk("R7", "still start-up", 32'(st), 32'h2);
        step(int'(N) - 3);
        chk("R7", "timer not paused", 32'(st), 32'h2);
        step(1);
        chk("R7", "active on time while hot", 32'(st), 32'h4);
        chk("R7", "hold kept in active", 32'(hold), 32'h1);
        hot = 1'b0;
        step(2);
        chk("R7", "released in active", 32'(hold), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(1);
        t_reset();
        t_sleep_blocked();
        go_active();
        t_wake_ignored_active();
        t_hot_active();
        t_uv_active();
        t_uv_at_expiry();
        t_hot_startup();
        t_uv_active();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule